// File: doc/BRIEF.md
# Segment Match and Collapse Network

This block sits on the read path of a compressed cache set. The set's data storage is one shared pool of 4-byte segments, and that pool is never compacted. A compressed line can own any mix of segments anywhere in the set. No pointer says where they are. Instead, every segment stores the identifier of the logical tag that owns it and a valid bit.

Once tag lookup has resolved a hit, the block receives the whole set (segment data, per-segment owner IDs and valid bits) together with the identifier of the tag that hit. In its first stage it compares that identifier against all owner IDs at once and registers a match mask. In its second stage a multiplexer crossbar packs the matching segments into a dense output buffer and registers it, ready for a decompressor. Beside the packed data it reports the number of segments gathered. It also flags a segment count that no legal compressed line can have.

Top module: `seg_gather`

## Requirements
- R1: A segment is selected when its valid bit is 1 and its 4-bit owner ID equals `hit_id`. Segment i occupies bits [32*i+31:32*i] of `seg_data` and bits [4*i+3:4*i] of `seg_tag`.
- R2: A segment whose valid bit is 0 is never gathered, even when its owner ID equals `hit_id`.
- R3: Selected segments are packed in ascending segment-index order. The lowest-indexed selected segment goes to output slot 0 (bits [31:0] of `out_line`), the next to slot 1 (bits [63:32]), and so on.
- R4: Every output slot at or above the gathered count is driven to zero. With no match, `out_line` is all zero.
- R5: `out_count` gives the number of segments gathered, which is the number selected, capped at 16.
- R6: `out_err` is 1 with a result when the number of selected segments is below 2 or above 16, and 0 for exactly 2 or exactly 16. When more than 16 are selected, the 16 lowest-indexed ones fill the slots.
- R7: A request sampled with `in_valid` high at one rising edge produces `out_valid` high, with its result, after the second rising edge. `out_valid` is low after the first. Requests on consecutive cycles produce results on consecutive cycles.
- R8: After reset, `out_valid`, `out_err`, `out_count` and `out_line` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request strobe for one set read |
| hit_id | input | 4 | Identifier of the logical tag that hit |
| seg_data | input | 2048 | Data of all 64 segments, 32 bits each |
| seg_tag | input | 256 | Owner ID of each segment, 4 bits each |
| seg_vld | input | 64 | Valid bit of each segment |
| out_valid | output | 1 | Result strobe |
| out_line | output | 512 | Packed segments, 16 slots of 32 bits |
| out_count | output | 5 | Number of segments gathered |
| out_err | output | 1 | Illegal segment count for this request |

## Verification
On every cycle the assertions check a few things: that the registered mask never holds a segment whose valid bit was clear, that the result strobe follows the stage-one strobe by exactly one edge, that the count stays within the slot count, and that an error flag only appears with a result and always appears when fewer than two segments were gathered. Only the bench's scenarios can show the contents of the packed line. That covers slot ordering for scattered owners, zero filling above the count, truncation to the lowest 16 indices on overflow, and the exact boundaries at 2 and 16 segments. Those need expected values built from the input pattern.

// File: rtl/seg_gather_pkg.sv
package seg_gather_pkg;
   localparam int unsigned DEF_SEG_BITS = 32;
   localparam int unsigned DEF_NSEG     = 64;
   localparam int unsigned DEF_NSLOT    = 16;
   localparam int unsigned DEF_ID_W     = 4;
   localparam int unsigned DEF_MIN_SEG  = 2;
endpackage

// File: rtl/seg_filter.sv
module seg_filter #(
   parameter int unsigned SEG_BITS = seg_gather_pkg::DEF_SEG_BITS,
   parameter int unsigned NSEG     = seg_gather_pkg::DEF_NSEG,
   parameter int unsigned ID_W     = seg_gather_pkg::DEF_ID_W
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     in_valid,
   input  logic [ID_W-1:0]          hit_id,
   input  logic [NSEG*SEG_BITS-1:0] seg_data,
   input  logic [NSEG*ID_W-1:0]     seg_tag,
   input  logic [NSEG-1:0]          seg_vld,
   output logic                     s1_valid,
   output logic [NSEG-1:0]          s1_mask,
   output logic [NSEG*SEG_BITS-1:0] s1_data
);
   logic [NSEG-1:0] hit_vec;

   for (genvar g = 0; g < NSEG; g++) begin : g_cmp
      assign hit_vec[g] = seg_vld[g] && (seg_tag[g*ID_W +: ID_W] == hit_id);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s1_valid <= 1'b0;
         s1_mask  <= '0;
         s1_data  <= '0;
      end else begin
         s1_valid <= in_valid;
         if (in_valid) begin
            s1_mask <= hit_vec;
            s1_data <= seg_data;
         end
      end
   end

   // R2
   invalid_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> ((s1_mask & ~$past(seg_vld)) == '0));
endmodule

// File: rtl/seg_collapse.sv
module seg_collapse #(
   parameter int unsigned SEG_BITS = seg_gather_pkg::DEF_SEG_BITS,
   parameter int unsigned NSEG     = seg_gather_pkg::DEF_NSEG,
   parameter int unsigned NSLOT    = seg_gather_pkg::DEF_NSLOT,
   parameter int unsigned CNT_W    = $clog2(NSEG + 1)
) (
   input  logic [NSEG-1:0]           mask,
   input  logic [NSEG*SEG_BITS-1:0]  data,
   output logic [NSLOT*SEG_BITS-1:0] line,
   output logic [CNT_W-1:0]          total
);
   // rank_q[i] = number of selected segments below index i
   logic [NSEG*CNT_W-1:0] rank_q;

   always_comb begin
      rank_q[CNT_W-1:0] = '0;
      for (int i = 1; i < NSEG; i++) begin
         rank_q[i*CNT_W +: CNT_W] = rank_q[(i-1)*CNT_W +: CNT_W]
                                    + CNT_W'(mask[i-1]);
      end
      total = rank_q[(NSEG-1)*CNT_W +: CNT_W] + CNT_W'(mask[NSEG-1]);
   end

   // crossbar: each output slot ORs the segment whose rank equals its index
   for (genvar k = 0; k < NSLOT; k++) begin : g_slot
      always_comb begin
         line[k*SEG_BITS +: SEG_BITS] = '0;
         for (int i = 0; i < NSEG; i++) begin
            if (mask[i] && (rank_q[i*CNT_W +: CNT_W] == CNT_W'(k))) begin
               line[k*SEG_BITS +: SEG_BITS] = line[k*SEG_BITS +: SEG_BITS]
                                              | data[i*SEG_BITS +: SEG_BITS];
            end
         end
      end
   end
endmodule

// File: rtl/seg_gather.sv
module seg_gather #(
   parameter int unsigned SEG_BITS = seg_gather_pkg::DEF_SEG_BITS,
   parameter int unsigned NSEG     = seg_gather_pkg::DEF_NSEG,
   parameter int unsigned NSLOT    = seg_gather_pkg::DEF_NSLOT,
   parameter int unsigned ID_W     = seg_gather_pkg::DEF_ID_W,
   parameter int unsigned MIN_SEG  = seg_gather_pkg::DEF_MIN_SEG
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           in_valid,
   input  logic [ID_W-1:0]                hit_id,
   input  logic [NSEG*SEG_BITS-1:0]       seg_data,
   input  logic [NSEG*ID_W-1:0]           seg_tag,
   input  logic [NSEG-1:0]                seg_vld,
   output logic                           out_valid,
   output logic [NSLOT*SEG_BITS-1:0]      out_line,
   output logic [$clog2(NSLOT+1)-1:0]     out_count,
   output logic                           out_err
);
   localparam int unsigned CNT_W  = $clog2(NSEG + 1);
   localparam int unsigned OCNT_W = $clog2(NSLOT + 1);

   if (NSLOT > NSEG || NSLOT == 0) begin : g_bad_slots
      $error("seg_gather: NSLOT must be in 1..NSEG");
   end
   if (MIN_SEG > NSLOT) begin : g_bad_min
      $error("seg_gather: MIN_SEG must not exceed NSLOT");
   end
   if (SEG_BITS == 0 || ID_W == 0) begin : g_bad_width
      $error("seg_gather: zero width");
   end

   logic                     s1_valid;
   logic [NSEG-1:0]          s1_mask;
   logic [NSEG*SEG_BITS-1:0] s1_data;
   logic [NSLOT*SEG_BITS-1:0] packed_line;
   logic [CNT_W-1:0]          match_total;
   logic                      too_few, too_many;

   seg_filter #(.SEG_BITS(SEG_BITS), .NSEG(NSEG), .ID_W(ID_W)) filter_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_valid (in_valid),
      .hit_id   (hit_id),
      .seg_data (seg_data),
      .seg_tag  (seg_tag),
      .seg_vld  (seg_vld),
      .s1_valid (s1_valid),
      .s1_mask  (s1_mask),
      .s1_data  (s1_data)
   );

   seg_collapse #(.SEG_BITS(SEG_BITS), .NSEG(NSEG), .NSLOT(NSLOT), .CNT_W(CNT_W)) collapse_i (
      .mask  (s1_mask),
      .data  (s1_data),
      .line  (packed_line),
      .total (match_total)
   );

   assign too_few  = match_total < CNT_W'(MIN_SEG);
   assign too_many = match_total > CNT_W'(NSLOT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_line  <= '0;
         out_count <= '0;
         out_err   <= 1'b0;
      end else begin
         out_valid <= s1_valid;
         out_err   <= s1_valid && (too_few || too_many);
         if (s1_valid) begin
            out_line  <= packed_line;
            out_count <= too_many ? OCNT_W'(NSLOT) : OCNT_W'(match_total);
         end
      end
   end

   // R7
   stage_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
      s1_valid |=> out_valid);
   // R7
   no_spurious_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !s1_valid |=> !out_valid);
   // R5
   count_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_count <= OCNT_W'(NSLOT));
   // R6
   short_line_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_count < OCNT_W'(MIN_SEG)) |-> out_err);
   // R6
   err_with_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_err |-> out_valid);
   // R4
   empty_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_count == '0) |-> (out_line == '0));
endmodule

// File: tb/seg_gather_tb_top.sv
module seg_gather_tb_top;
   localparam int NSEG = 64, NSLOT = 16, W = 32, ID_W = 4;

   logic clk = 1'b0;
   always #10 clk = ~clk;

   logic                   rst_n;
   logic                   in_valid;
   logic [ID_W-1:0]        hit_id;
   logic [NSEG*W-1:0]      seg_data;
   logic [NSEG*ID_W-1:0]   seg_tag;
   logic [NSEG-1:0]        seg_vld;
   logic                   out_valid;
   logic [NSLOT*W-1:0]     out_line;
   logic [4:0]             out_count;
   logic                   out_err;

   seg_gather dut_i (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .hit_id(hit_id),
      .seg_data(seg_data), .seg_tag(seg_tag), .seg_vld(seg_vld),
      .out_valid(out_valid), .out_line(out_line), .out_count(out_count),
      .out_err(out_err)
   );

   int total = 0;
   int bad = 0;
   logic [NSLOT*W-1:0] e_line;
   int                 e_cnt;
   bit                 e_err;

   task automatic check(string req, string what, logic [NSLOT*W-1:0] act,
                        logic [NSLOT*W-1:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic compute();
      int cnt = 0;
      e_line = '0;
      for (int i = 0; i < NSEG; i++) begin
         if (seg_vld[i] && seg_tag[i*ID_W +: ID_W] == hit_id) begin
            if (cnt < NSLOT) e_line[cnt*W +: W] = seg_data[i*W +: W];
            cnt++;
         end
      end
      e_err = (cnt < 2) || (cnt > NSLOT);
      e_cnt = (cnt > NSLOT) ? NSLOT : cnt;
   endtask

   task automatic base_fill(int seed);
      for (int i = 0; i < NSEG; i++) begin
         seg_data[i*W +: W] = 32'h5A00_0000 ^ (i * 32'h0101_0103) ^ seed;
         seg_tag[i*ID_W +: ID_W] = ID_W'((i * 7) % 16);
      end
      seg_vld = '1;
   endtask

   task automatic tags_all(int t);
      for (int i = 0; i < NSEG; i++) seg_tag[i*ID_W +: ID_W] = ID_W'(t);
   endtask

   task automatic check_result(string req, logic [NSLOT*W-1:0] el, int ec, bit ee);
      check("R7", "out_valid", {511'd0, out_valid}, 512'd1);
      check(req, "out_line", out_line, el);
      check("R5", "out_count", {507'd0, out_count}, 512'(ec));
      check("R6", "out_err", {511'd0, out_err}, {511'd0, ee});
   endtask

   // called at a negedge with inputs set up; in_valid is raised here
   task automatic fire(string req);
      compute();
      in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
      check("R7", "out_valid early", {511'd0, out_valid}, 512'd0);
      @(negedge clk);
      check_result(req, e_line, e_cnt, e_err);
   endtask

   task automatic t_reset();
      check("R8", "out_valid", {511'd0, out_valid}, 512'd0);
      check("R8", "out_line", out_line, 512'd0);
      check("R8", "out_count", {507'd0, out_count}, 512'd0);
      check("R8", "out_err", {511'd0, out_err}, 512'd0);
   endtask

   task automatic t_scatter();  // R1 R3: owner 5 sits at 3, 19, 35, 51
      base_fill(1);
      hit_id = 4'd5;
      fire("R1/R3");
      check("R3", "slot1 holds seg19", {480'd0, out_line[63:32]},
            {480'd0, seg_data[19*W +: W]});
   endtask

   task automatic t_invalid();  // R2
      base_fill(2);
      hit_id = 4'd5;
      seg_vld[19] = 1'b0;
      seg_tag[60*ID_W +: ID_W] = 4'd5;
      seg_vld[60] = 1'b0;
      fire("R2");
      check("R2", "count with masked", {507'd0, out_count}, 512'd3);
   endtask

   task automatic t_full16();  // R6 upper boundary, no error
      base_fill(3);
      tags_all(15);
      for (int j = 0; j < 16; j++) seg_tag[(j*4)*ID_W +: ID_W] = 4'd9;
      hit_id = 4'd9;
      fire("R3/R6");
   endtask

   task automatic t_over();  // R6 overflow: lowest 16 kept
      base_fill(4);
      tags_all(15);
      for (int j = 0; j < 20; j++) seg_tag[(2*j+1)*ID_W +: ID_W] = 4'd9;
      hit_id = 4'd9;
      fire("R6");
      check("R6", "err on overflow", {511'd0, out_err}, 512'd1);
   endtask

   task automatic t_single();  // R4 R6: one segment
      base_fill(5);
      tags_all(0);
      seg_tag[63*ID_W +: ID_W] = 4'd12;
      hit_id = 4'd12;
      fire("R4/R6");
      check("R4", "upper slots zero", {32'd0, out_line[511:32]}, 512'd0);
   endtask

   task automatic t_none();  // R4: no match
      base_fill(6);
      tags_all(0);
      hit_id = 4'd3;
      fire("R4");
      check("R4", "empty line", out_line, 512'd0);
   endtask

   task automatic t_two();  // R6 lower boundary, R3 extremes
      base_fill(7);
      tags_all(0);
      seg_tag[0 +: ID_W] = 4'd14;
      seg_tag[63*ID_W +: ID_W] = 4'd14;
      hit_id = 4'd14;
      fire("R3/R6");
   endtask

   task automatic t_b2b();  // R7 back-to-back
      logic [NSLOT*W-1:0] a_line;
      int a_cnt;
      bit a_err;
      base_fill(8);
      hit_id = 4'd5;
      compute();
      a_line = e_line; a_cnt = e_cnt; a_err = e_err;
      in_valid = 1'b1;
      @(negedge clk);
      hit_id = 4'd6;
      compute();
      @(negedge clk);
      in_valid = 1'b0;
      check_result("R7", a_line, a_cnt, a_err);
      @(negedge clk);
      check_result("R7", e_line, e_cnt, e_err);
      @(negedge clk);
      check("R7", "idle after burst", {511'd0, out_valid}, 512'd0);
   endtask

   bit finished = 1'b0;

   initial begin
      rst_n = 1'b0;
      in_valid = 1'b0;
      hit_id = '0;
      seg_data = '0;
      seg_tag = '0;
      seg_vld = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_scatter();
      t_invalid();
      t_full16();
      t_over();
      t_single();
      t_none();
      t_two();
      t_b2b();
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!finished) begin
         total++;
         bad++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule